// File: doc/BRIEF.md
# Exclusive Access Monitor

This block tracks one reservation for a load-exclusive / store-exclusive semaphore scheme. An exclusive load records the word address it touched as a live reservation. A later exclusive store to that same word is allowed to write memory and reports success. Every exclusive store uses up the reservation, whether it passes or fails. An exclusive store that finds no matching reservation is kept from writing memory and reports failure.

The block sits beside a single requester's memory port. Each cycle the requester presents a strobe, an access kind and an address. The monitor answers in the same cycle with two outputs. The write gate decides whether the memory array accepts the store. The status word is placed in the destination register of an exclusive store. A parameter chooses whether an ordinary store to the reserved word also cancels the reservation.

Top module: `exclusive_monitor`

## Requirements
- R1: After synchronous reset no reservation is held, so the first exclusive store fails.
- R2: An exclusive load (kind code 1) records its word address. A following exclusive store (kind code 2) to the same word raises the write gate and returns status 0.
- R3: An exclusive store with no matching reservation holds the write gate low and returns status 1.
- R4: Every exclusive store clears the reservation, so a second exclusive store to the same word fails.
- R5: An exclusive store to a word other than the reserved one fails and also clears the reservation.
- R6: Address bits [1:0] are ignored in the compare. The reservation covers one aligned 32-bit word.
- R7: An ordinary store (kind code 3) always raises the write gate. With CLEAR_ON_STORE=1 (the default), an ordinary store to the reserved word cancels the reservation. An ordinary store to any other word leaves the reservation intact.
- R8: A new exclusive load replaces any reservation already held.
- R9: Kind code 0, or any cycle with the strobe low, leaves the write gate low and does not change the reservation.
- R10: The status word is zero in every cycle that is not a strobed exclusive store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_kind_i | input | 2 | 0 other, 1 exclusive load, 2 exclusive store, 3 ordinary store |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| wr_gate_o | output | 1 | Memory write permitted this cycle |
| xs_status_o | output | STATUS_W | Exclusive-store result: 0 pass, 1 fail |

## Verification
Within one cycle, an exclusive store both reaches its pass/fail verdict and clears the reservation it is judged against. The verdict must come from the reservation as it stood before that edge. The bench provokes this by issuing exclusive stores back to back to the same word, and by following a passing store at once with another store. It then checks that only the first passes. A second overlap comes from an ordinary store that gets its write while it cancels a matching reservation. The bench checks this through the verdict of the exclusive store that follows.

// File: rtl/exm_pkg.sv
package exm_pkg;

    typedef enum logic [1:0] {
        ACC_OTHER  = 2'd0,
        ACC_XLOAD  = 2'd1,
        ACC_XSTORE = 2'd2,
        ACC_STORE  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic write_ok;
        logic fail;
        logic set;
        logic clear;
    } verdict_t;

    function automatic verdict_t judge(input logic strobe, input acc_kind_e kind,
                                       input logic hit, input logic store_clears);
        verdict_t v;
        v = '0;
        if (strobe) begin
            unique case (kind)
                ACC_XLOAD:  v.set = 1'b1;
                ACC_XSTORE: begin
                    v.write_ok = hit;
                    v.fail     = !hit;
                    v.clear    = 1'b1;
                end
                ACC_STORE: begin
                    v.write_ok = 1'b1;
                    v.clear    = store_clears && hit;
                end
                default: v = '0;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/exm_tag_reg.sv
module exm_tag_reg #(
    parameter int TAG_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_i,
    input  logic             clear_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             valid_o,
    output logic [TAG_W-1:0] tag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            tag_o   <= '0;
        end else if (set_i) begin
            valid_o <= 1'b1;
            tag_o   <= tag_i;
        end else if (clear_i) begin
            valid_o <= 1'b0;
        end
    end

    a_r8_set_loads_tag: assert property (@(posedge clk) disable iff (rst)
        set_i |=> (valid_o && tag_o == $past(tag_i)));
    a_r4_clear_drops_valid: assert property (@(posedge clk) disable iff (rst)
        (clear_i && !set_i) |=> !valid_o);
endmodule

// File: rtl/exm_match.sv
module exm_match #(
    parameter int TAG_W = 30
) (
    input  logic             valid_i,
    input  logic [TAG_W-1:0] held_i,
    input  logic [TAG_W-1:0] probe_i,
    output logic             hit_o
);
    always_comb hit_o = valid_i && (held_i == probe_i);
endmodule

// File: rtl/exclusive_monitor.sv
module exclusive_monitor
    import exm_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int GRAN_BYTES     = 4,
    parameter int STATUS_W       = 32,
    parameter bit CLEAR_ON_STORE = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_valid_i,
    input  logic [1:0]          acc_kind_i,
    input  logic [ADDR_W-1:0]   acc_addr_i,
    output logic                wr_gate_o,
    output logic [STATUS_W-1:0] xs_status_o
);
    localparam int LSB   = $clog2(GRAN_BYTES);
    localparam int TAG_W = ADDR_W - LSB;

    logic [TAG_W-1:0] probe, held;
    logic             held_valid, hit;
    acc_kind_e        kind;
    verdict_t         vd;

    assign probe = acc_addr_i[ADDR_W-1:LSB];
    assign kind  = acc_kind_e'(acc_kind_i);

    exm_match #(.TAG_W(TAG_W)) u_match (
        .valid_i(held_valid), .held_i(held), .probe_i(probe), .hit_o(hit)
    );

    always_comb vd = judge(acc_valid_i, kind, hit, CLEAR_ON_STORE);

    exm_tag_reg #(.TAG_W(TAG_W)) u_tag (
        .clk(clk), .rst(rst), .set_i(vd.set), .clear_i(vd.clear),
        .tag_i(probe), .valid_o(held_valid), .tag_o(held)
    );

    assign wr_gate_o   = vd.write_ok;
    assign xs_status_o = {{(STATUS_W-1){1'b0}}, vd.fail};

    a_r3_fail_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (xs_status_o != '0) |-> !wr_gate_o);
    a_r10_status_quiet: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid_i && acc_kind_i == 2'd2) |-> (xs_status_o == '0));
    a_r9_idle_keeps_state: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid_i || acc_kind_i == 2'd0) |=> ($stable(held_valid) && !$past(wr_gate_o)));
    a_r4_xstore_consumes: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && acc_kind_i == 2'd2) |=> !held_valid);
    a_r2_pass_needs_hit: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && acc_kind_i == 2'd2 && wr_gate_o) |-> (held_valid && held == probe));
endmodule

// File: tb/test_exclusive_monitor.sv
module test_exclusive_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stb = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic [31:0] addr = '0;
    logic        gate;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;
    logic        m_valid = 1'b0;
    logic [29:0] m_tag = '0;

    always #4 clk = ~clk;

    exclusive_monitor i_exclusive_monitor (
        .clk(clk), .rst(rst), .acc_valid_i(stb), .acc_kind_i(kind),
        .acc_addr_i(addr), .wr_gate_o(gate), .xs_status_o(status)
    );

    function automatic logic exp_hit(logic [31:0] a);
        return m_valid && (a[31:2] == m_tag);
    endfunction
    function automatic logic exp_gate(logic s, logic [1:0] k, logic [31:0] a);
        if (!s) return 1'b0;
        if (k == 2'd3) return 1'b1;
        if (k == 2'd2) return exp_hit(a);
        return 1'b0;
    endfunction
    function automatic logic [31:0] exp_status(logic s, logic [1:0] k, logic [31:0] a);
        if (s && k == 2'd2) return exp_hit(a) ? 32'd0 : 32'd1;
        return 32'd0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(string req, logic s, logic [1:0] k, logic [31:0] a);
        logic g;
        logic [31:0] st;
        @(negedge clk);
        stb = s; kind = k; addr = a;
        #3;
        g  = exp_gate(s, k, a);
        st = exp_status(s, k, a);
        check(req, {31'd0, gate}, {31'd0, g});
        check(req, status, st);
        @(posedge clk);
        if (s) begin
            if (k == 2'd1) begin m_valid = 1'b1; m_tag = a[31:2]; end
            else if (k == 2'd2) m_valid = 1'b0;
            else if (k == 2'd3 && exp_hit(a)) m_valid = 1'b0;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] pool [4];
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #3;
        check("R1 reset gate", {31'd0, gate}, 32'd0);
        check("R10 reset status", status, 32'd0);
        op("R1", 1, 2'd2, 32'h100);
        op("R2", 1, 2'd1, 32'h100);
        op("R2 R6", 1, 2'd2, 32'h102);
        op("R4", 1, 2'd2, 32'h100);
        op("R5", 1, 2'd1, 32'h200);
        op("R5", 1, 2'd2, 32'h204);
        op("R5", 1, 2'd2, 32'h200);
        op("R8", 1, 2'd1, 32'h300);
        op("R8", 1, 2'd1, 32'h400);
        op("R8", 1, 2'd2, 32'h300);
        op("R8", 1, 2'd1, 32'h300);
        op("R8", 1, 2'd2, 32'h303);
        op("R7", 1, 2'd1, 32'h500);
        op("R7", 1, 2'd3, 32'h501);
        op("R7", 1, 2'd2, 32'h500);
        op("R7", 1, 2'd1, 32'h500);
        op("R7", 1, 2'd3, 32'h600);
        op("R7", 1, 2'd2, 32'h500);
        op("R9", 1, 2'd1, 32'h700);
        op("R9", 1, 2'd0, 32'h700);
        op("R9", 0, 2'd2, 32'h700);
        op("R9", 0, 2'd3, 32'h700);
        op("R9 R10", 1, 2'd2, 32'h701);
        op("R3", 1, 2'd2, 32'h800);
        pool[0] = 32'h1000; pool[1] = 32'h1004; pool[2] = 32'h2000; pool[3] = 32'h2008;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = pool[$urandom_range(0, 3)] | {30'd0, 2'($urandom_range(0, 3))};
            op("R2 R3 R4 R7 R10 random", ($urandom_range(0, 7) != 0),
               2'($urandom_range(0, 3)), a);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule